// File: doc/BRIEF.md
# Boolean pattern match engine

This block watches eight asynchronous digital inputs and raises interrupts when programmed sum-of-products expressions over them become true. It is built from eight chained bit slices. Each slice picks one of the inputs, applies a programmable detect condition (level, sticky edge, one-cycle edge event, or a constant), and ANDs its result into a running product. An endpoint flag on a slice closes the current product term and starts a fresh one at the next slice. Each closed term drives its own interrupt bit, and the OR of all terms drives one global match output.

Software programs the block through a small write-only register bus. One register holds the per-slice source selects, one holds the per-slice conditions and endpoint flags, one holds a control bit, and one address is a pure clear strobe. Writing the source or condition register also clears the sticky detectors, so reconfiguration cannot leave a stale edge behind. A control bit chooses whether the interrupt outputs carry the product-term results or pass through the ordinary per-pin interrupts from outside the block.

Each slice holds its edge memory in a two-state machine. In state ARMED the slice waits; the transition ARMED to HELD is taken when the slice's sticky condition sees its qualifying edge and no clear is requested in that cycle. The transition HELD to ARMED is taken on any clear. Outside the sticky conditions the machine stays in ARMED.

Top module: `pmatch_engine`

## Requirements
- R1: While rst_n is low, term_irq and match_any are 0. All registers reset to zero, which makes every slice always-true with slice 7 as the sole endpoint, so from the second rising edge after reset release term_irq is 8'h80 and match_any is 1.
- R2: A write to address 0 sets the source of slice n from data bits 8+3n to 10+3n; value k makes slice n read input k.
- R3: A write to address 1 sets the condition of slice n from data bits 8+3n to 10+3n. Codes: 0 always true, 4 input high, 5 input low, 6 never true.
- R4: Condition codes 1 (rising edge), 2 (falling edge) and 3 (either edge) are sticky: once the qualifying edge is seen after a clear, the slice stays true until the next clear, whatever the input does.
- R5: Condition code 7 makes the slice true for exactly one cycle per input edge, with no memory.
- R6: Data bit n (n = 0 to 6) of an address-1 write marks slice n as an endpoint. A term is the AND of the slices from the one after the previous endpoint up to its endpoint, and term_irq bit n is that term's value; bits of non-endpoint slices are 0.
- R7: Slice 7 always closes a term, whatever the other endpoint bits say.
- R8: match_any equals the OR of all term_irq bits in every cycle.
- R9: A write to address 2 stores data bit 0 as the replace bit; when it is 1, irq_out equals term_irq; when it is 0, irq_out equals pin_irq_in.
- R10: A write to address 3, address 0 or address 1 clears every sticky detector; a write to address 2 does not.
- R11: An input change applied before rising edge k is first visible on term_irq after rising edge k+2 (two synchronizer flops and one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Asynchronous inputs observed by the slices |
| pin_irq_in | input | 8 | Ordinary per-pin interrupts from outside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 sources, 1 conditions and endpoints, 2 control, 3 clear |
| wr_data | input | 32 | Register write data |
| term_irq | output | 8 | One registered interrupt per endpoint slice |
| match_any | output | 1 | Registered OR of all product terms |
| irq_out | output | 8 | Interrupt outputs, either term_irq or pin_irq_in |

## Verification
Every cycle the assertions check that the global match agrees with the term bits, that only endpoint slices can raise a term bit, that interrupt outputs come only from one of the two sources, that a held sticky detector never drops without a clear, and that a clear empties every detector. Which input a slice reads, each condition code, the one-cycle width of edge events, the exact pipeline latency and the selection between term and pin interrupts depend on the stimulus and the chosen configuration, so only the bench's table of configurations and its directed scenarios can show them.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int COND_W    = 3;
    localparam int FIELD_LSB = 8;

    typedef enum logic [COND_W-1:0] {
        COND_TRUE     = 3'd0,
        COND_RISE_STK = 3'd1,
        COND_FALL_STK = 3'd2,
        COND_BOTH_STK = 3'd3,
        COND_HIGH     = 3'd4,
        COND_LOW      = 3'd5,
        COND_FALSE    = 3'd6,
        COND_EDGE_EVT = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        ADDR_SRC  = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_CLR  = 2'd3
    } addr_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } sticky_e;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pm_pkg::*;
#(
    parameter int N_SLICE = 8,
    parameter int SEL_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [1:0]                         wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [N_SLICE-1:0][SEL_W-1:0]      src_sel,
    output logic [N_SLICE-1:0][COND_W-1:0]     cond,
    output logic [N_SLICE-2:0]                 ep_flags,
    output logic                               replace,
    output logic                               clr_pulse
);
    localparam int TOP_BIT = FIELD_LSB + COND_W * N_SLICE - 1;

    addr_e addr;
    assign addr = addr_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel  <= '0;
            cond     <= '0;
            ep_flags <= '0;
            replace  <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_SRC: begin
                    for (int n = 0; n < N_SLICE; n++) begin
                        src_sel[n] <= wr_data[FIELD_LSB + COND_W*n +: SEL_W];
                    end
                end
                ADDR_CFG: begin
                    for (int n = 0; n < N_SLICE; n++) begin
                        cond[n] <= wr_data[FIELD_LSB + COND_W*n +: COND_W];
                    end
                    ep_flags <= wr_data[N_SLICE-2:0];
                end
                ADDR_CTRL: replace <= wr_data[0];
                ADDR_CLR:  ;
            endcase
        end
    end

    assign clr_pulse = wr_en && (addr != ADDR_CTRL);

    logic unused_bits;
    assign unused_bits = ^{wr_data[FIELD_LSB-1:N_SLICE-1]};

    initial begin
        if (TOP_BIT >= DATA_W) $display("pm_regs: field layout exceeds data width");
    end
endmodule

// File: rtl/pm_slice.sv
module pm_slice
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_bit,
    input  logic [COND_W-1:0] cond,
    input  logic              clr,
    output logic              det,
    output logic              held
);
    cond_e   mode;
    sticky_e state_q, state_d;
    logic    prev_q;
    logic    rise, fall, hit;

    assign mode = cond_e'(cond);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= in_bit;
    end

    assign rise = in_bit & ~prev_q;
    assign fall = ~in_bit & prev_q;

    always_comb begin
        unique case (mode)
            COND_RISE_STK: hit = rise;
            COND_FALL_STK: hit = fall;
            COND_BOTH_STK: hit = rise | fall;
            default:       hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (!clr && hit) state_d = ST_HELD;
            ST_HELD:  if (clr)         state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (mode)
            COND_TRUE:     det = 1'b1;
            COND_RISE_STK,
            COND_FALL_STK,
            COND_BOTH_STK: det = (state_q == ST_HELD) | hit;
            COND_HIGH:     det = in_bit;
            COND_LOW:      det = ~in_bit;
            COND_FALSE:    det = 1'b0;
            COND_EDGE_EVT: det = rise | fall;
        endcase
    end

    assign held = (state_q == ST_HELD);
endmodule

// File: rtl/pmatch_engine.sv
module pmatch_engine
    import pm_pkg::*;
#(
    parameter int N_SLICE     = 8,
    parameter int N_IN        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN-1:0]    pin_in,
    input  logic [N_SLICE-1:0] pin_irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [N_SLICE-1:0] term_irq,
    output logic               match_any,
    output logic [N_SLICE-1:0] irq_out
);
    localparam int SEL_W = $clog2(N_IN);

    logic [N_IN-1:0]                   sync_q;
    logic [N_SLICE-1:0][SEL_W-1:0]     src_sel;
    logic [N_SLICE-1:0][COND_W-1:0]    cond;
    logic [N_SLICE-2:0]                ep_flags;
    logic [N_SLICE-1:0]                ep_eff;
    logic                              replace;
    logic                              clr_pulse;
    logic [N_SLICE-1:0]                det;
    logic [N_SLICE-1:0]                held_vec;
    logic [N_SLICE-1:0]                term_d;

    pm_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    pm_regs #(.N_SLICE(N_SLICE), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_sel(src_sel), .cond(cond), .ep_flags(ep_flags),
        .replace(replace), .clr_pulse(clr_pulse)
    );

    assign ep_eff = {1'b1, ep_flags};

    for (genvar n = 0; n < N_SLICE; n++) begin : g_slice
        pm_slice u_slice (
            .clk(clk), .rst_n(rst_n),
            .in_bit(sync_q[src_sel[n]]),
            .cond(cond[n]),
            .clr(clr_pulse),
            .det(det[n]),
            .held(held_vec[n])
        );
    end

    always_comb begin
        logic run;
        run = 1'b1;
        for (int n = 0; n < N_SLICE; n++) begin
            run       = run & det[n];
            term_d[n] = run & ep_eff[n];
            if (ep_eff[n]) run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_irq  <= '0;
            match_any <= 1'b0;
        end else begin
            term_irq  <= term_d;
            match_any <= |term_d;
        end
    end

    assign irq_out = replace ? term_irq : pin_irq_in;
endmodule

// File: rtl/pmatch_engine_chk.sv
module pmatch_engine_chk #(
    parameter int N_SLICE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SLICE-1:0] term_irq,
    input logic               match_any,
    input logic [N_SLICE-1:0] irq_out,
    input logic [N_SLICE-1:0] pin_irq_in,
    input logic [N_SLICE-2:0] ep_bits,
    input logic [N_SLICE-1:0] held,
    input logic               clr
);
    // R8
    match_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_any == (|term_irq));

    // R6
    endpoint_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_irq[N_SLICE-2:0] & ~$past(ep_bits)) == '0);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~(term_irq | pin_irq_in)) == '0);

    // R4
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(held) & ~held) == '0));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (held == '0));
endmodule

bind pmatch_engine pmatch_engine_chk #(.N_SLICE(N_SLICE)) u_chk (
    .clk(clk), .rst_n(rst_n), .term_irq(term_irq), .match_any(match_any),
    .irq_out(irq_out), .pin_irq_in(pin_irq_in), .ep_bits(ep_flags),
    .held(held_vec), .clr(clr_pulse)
);

// File: tb/pmatch_engine_bench.sv
`timescale 1ns/1ps
module pmatch_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_irq_in = 8'h3C;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  term_irq;
    logic        match_any;
    logic [7:0]  irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pmatch_engine u_pmatch_engine (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_irq_in(pin_irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .term_irq(term_irq), .match_any(match_any), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [23:0] src;
        logic [23:0] cond;
        logic [6:0]  ep;
        logic [7:0]  pins;
        logic [7:0]  exp;
    } vec_t;

    localparam logic [23:0] SRC_ID  = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
    localparam logic [23:0] SRC_REV = {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7};
    localparam logic [23:0] SRC_Z   = 24'd0;
    localparam logic [23:0] C_HI    = {8{3'd4}};
    localparam logic [23:0] C_LO    = {8{3'd5}};
    localparam logic [23:0] C_ALW   = 24'd0;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{SRC_ID,  C_HI,  7'h00, 8'hFF, 8'h80},   // R3 R7 one long term
        '{SRC_ID,  C_HI,  7'h00, 8'h7F, 8'h00},
        '{SRC_ID,  C_HI,  7'h7F, 8'hA5, 8'hA5},   // R6 one term per slice
        '{SRC_ID,  C_LO,  7'h7F, 8'hA5, 8'h5A},   // R3 low level
        '{SRC_ID,  C_HI,  7'h0F, 8'h0F, 8'h0F},   // R6 mixed term lengths
        '{SRC_ID,  C_HI,  7'h0F, 8'hF0, 8'h80},
        '{SRC_Z,   C_HI,  7'h00, 8'h01, 8'h80},   // R2 all slices read input 0
        '{SRC_Z,   C_HI,  7'h00, 8'hFE, 8'h00},
        '{SRC_REV, C_HI,  7'h7F, 8'h01, 8'h80},   // R2 reversed selects
        '{SRC_REV, C_HI,  7'h7F, 8'h80, 8'h01},
        '{SRC_ID,  {21'd0,3'd6}, 7'h01, 8'h00, 8'h80},  // R3 never-true slice 0
        '{SRC_ID,  {3'd6,21'd0}, 7'h00, 8'hFF, 8'h00},  // R3 never-true slice 7
        '{SRC_ID,  C_ALW, 7'h55, 8'h00, 8'hD5},   // R6 R7 alternating endpoints
        '{SRC_ID,  C_ALW, 7'h7F, 8'h00, 8'hFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg_word(input logic [23:0] c, input logic [6:0] e);
        return {c, 1'b0, e};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        settle(3);
        check("R1 term_irq in reset", {24'd0, term_irq}, 32'h0);
        check("R1 match_any in reset", {31'd0, match_any}, 32'h0);
        check("R9 irq_out passes pins at reset", {24'd0, irq_out}, {24'd0, pin_irq_in});
        rst_n = 1'b1;
        settle(2);
        check("R1 term_irq after reset", {24'd0, term_irq}, 32'h80);
        check("R1 match_any after reset", {31'd0, match_any}, 32'h1);

        // R2 R3 R6 R7 R8 table of configurations
        for (int i = 0; i < NV; i++) begin
            bus_write(2'd0, {VECS[i].src, 8'h00});
            bus_write(2'd1, cfg_word(VECS[i].cond, VECS[i].ep));
            pin_in = VECS[i].pins;
            settle(5);
            check($sformatf("R2 R3 R6 vector %0d term_irq", i), {24'd0, term_irq}, {24'd0, VECS[i].exp});
            check($sformatf("R8 vector %0d match_any", i), {31'd0, match_any}, {31'd0, |VECS[i].exp});
        end

        // R11 latency: slice 0 high level, own term
        bus_write(2'd0, {SRC_ID, 8'h00});
        bus_write(2'd1, cfg_word({21'd0, 3'd4}, 7'h01));
        pin_in = 8'h00;
        settle(5);
        @(negedge clk); pin_in = 8'h01;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 not yet after two edges", {31'd0, term_irq[0]}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11 visible after third edge", {31'd0, term_irq[0]}, 32'h1);

        // R4 sticky rising on slice 0
        pin_in = 8'h00;
        settle(4);
        bus_write(2'd1, cfg_word({21'd0, 3'd1}, 7'h01));
        settle(5);
        check("R4 rising armed", {31'd0, term_irq[0]}, 32'h0);
        pin_in = 8'h01; settle(5);
        check("R4 rising caught", {31'd0, term_irq[0]}, 32'h1);
        pin_in = 8'h00; settle(5);
        check("R4 rising held after input drop", {31'd0, term_irq[0]}, 32'h1);

        // R9 replace bit; R10 control write keeps sticky state
        bus_write(2'd2, 32'h1);
        settle(2);
        check("R9 irq_out follows terms", {24'd0, irq_out}, 32'h81);
        check("R10 control write keeps sticky", {31'd0, term_irq[0]}, 32'h1);
        bus_write(2'd2, 32'h0);
        settle(1);
        check("R9 irq_out follows pins", {24'd0, irq_out}, 32'h3C);

        // R10 clear strobe
        bus_write(2'd3, 32'h0);
        settle(3);
        check("R10 clear strobe empties sticky", {31'd0, term_irq[0]}, 32'h0);

        // R10 source write also clears
        pin_in = 8'h01; settle(5);
        check("R4 rising caught again", {31'd0, term_irq[0]}, 32'h1);
        bus_write(2'd0, {SRC_ID, 8'h00});
        settle(3);
        check("R10 source write clears sticky", {31'd0, term_irq[0]}, 32'h0);

        // R4 sticky falling
        bus_write(2'd1, cfg_word({21'd0, 3'd2}, 7'h01));
        settle(5);
        check("R4 falling armed", {31'd0, term_irq[0]}, 32'h0);
        pin_in = 8'h00; settle(5);
        check("R4 falling caught", {31'd0, term_irq[0]}, 32'h1);
        pin_in = 8'h01; settle(5);
        check("R4 falling held", {31'd0, term_irq[0]}, 32'h1);

        // R4 sticky either edge
        bus_write(2'd1, cfg_word({21'd0, 3'd3}, 7'h01));
        settle(5);
        check("R4 either armed", {31'd0, term_irq[0]}, 32'h0);
        pin_in = 8'h00; settle(5);
        check("R4 either caught", {31'd0, term_irq[0]}, 32'h1);

        // R5 one-cycle edge events
        bus_write(2'd1, cfg_word({21'd0, 3'd7}, 7'h01));
        settle(5);
        begin
            int cnt;
            cnt = 0;
            @(negedge clk); pin_in = 8'h01;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (term_irq[0]) cnt++;
            end
            check("R5 rise event width", cnt, 1);
            cnt = 0;
            pin_in = 8'h00;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (term_irq[0]) cnt++;
            end
            check("R5 fall event width", cnt, 1);
        end

        finish_run();
    end
endmodule